// File: doc/BRIEF.md
# Tagged Dispatch and In-Order Reorder Unit

This block takes one stream of work items and spreads it over several parallel processing units. It then puts the results back into the order in which the items arrived. Each accepted item is stamped with a wrapping sequence tag and goes to the unit that currently holds the fewest unfinished items. Units may finish in any order. Each result comes back carrying its tag and is parked in a reorder store slot chosen by that tag. A single output stream then releases results strictly oldest-first.

All ports use valid/ready handshakes. Intake stops whenever the reorder store could not hold one more item, which is when the number of items accepted but not yet delivered equals the store depth. The processing units sit outside the block. The store depth must be a power of two and at least 2.

Top module: `tag_dispatch_reorder`

## Requirements
- R1: After reset, `out_valid` is 0, `res_ready` is all zeros, `disp_valid` is all zeros while `in_valid` is 0, and `in_ready` is 1 when unit 0 signals ready.
- R2: The tag carried with an accepted item equals the number of items accepted before it, modulo 2*DEPTH (tag width log2(DEPTH)+1 bits).
- R3: An item is offered to the unit with the smallest count of outstanding items (dispatched and not yet returned). Ties go to the lowest unit index.
- R4: At most one bit of `disp_valid` is high. It is high exactly when `in_valid` is 1 and the store is not full. The item data appears unchanged on that unit's `disp_data` slice (slice u occupies bits u*DATA_W upward).
- R5: `in_ready` is 0 while DEPTH items are accepted but not yet delivered, or while the chosen unit's `disp_ready` is 0. Otherwise it is 1.
- R6: `res_ready` is one-hot or zero. It grants the lowest-indexed unit whose `res_valid` is 1, and one result is taken per cycle.
- R7: Results leave on `out_data` in exactly the order their items were accepted, with the data each unit returned.
- R8: `out_valid` is 1 only when the oldest undelivered item's result has returned. Younger results already held do not make it 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R10: Tags wrap from 2*DEPTH-1 to 0 without disturbing order or dispatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming item is present |
| in_data | input | DATA_W | Incoming item payload |
| in_ready | output | 1 | Item accepted this cycle if valid |
| disp_valid | output | N_UNITS | Per-unit offer of the current item |
| disp_data | output | N_UNITS*DATA_W | Per-unit item payload slices |
| disp_tag | output | N_UNITS*TAG_W | Per-unit sequence tag slices |
| disp_ready | input | N_UNITS | Per-unit acceptance |
| res_valid | input | N_UNITS | Per-unit result present |
| res_data | input | N_UNITS*DATA_W | Per-unit result payload slices |
| res_tag | input | N_UNITS*TAG_W | Per-unit result tag slices |
| res_ready | output | N_UNITS | Per-unit result taken |
| out_valid | output | 1 | Oldest result is available |
| out_data | output | DATA_W | Oldest result payload |
| out_ready | input | 1 | Consumer takes the result |

## Verification
The hardest states to reach are a blocked head of line and a completely full store. In the first, younger results are already parked but the oldest is still in flight. In the second, intake stops while the consumer stalls. The bench models the units as in-order pipelines with a chosen latency per unit. One phase makes unit 0 far slower than the rest, so the first item, which the tie rule sends to unit 0, returns long after its successors. Another phase holds `out_ready` low until the store fills, then releases it. A long randomized phase pushes enough items through to wrap the tags several times.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    localparam int unsigned TDR_UNITS_DEF  = 4;
    localparam int unsigned TDR_DEPTH_DEF  = 16;
    localparam int unsigned TDR_DATA_W_DEF = 16;

    // One extra bit beyond the slot index separates full from empty.
    function automatic int unsigned tdr_tag_width(int unsigned depth);
        return $clog2(depth) + 1;
    endfunction

    function automatic int unsigned tdr_index_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tdr_busy_track.sv
module tdr_busy_track #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned UNIT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_fire,
    input  logic [UNIT_W-1:0] disp_unit,
    input  logic              ret_fire,
    input  logic [UNIT_W-1:0] ret_unit,
    output logic [UNIT_W-1:0] pick
);
    typedef struct packed {
        logic [N_UNITS-1:0][CNT_W-1:0] cnt;
    } busy_state_t;

    busy_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < int'(N_UNITS); i++) begin
            if (disp_fire && disp_unit == UNIT_W'(i))
                s_d.cnt[i] = s_d.cnt[i] + CNT_W'(1);
            if (ret_fire && ret_unit == UNIT_W'(i))
                s_d.cnt[i] = s_d.cnt[i] - CNT_W'(1);
        end
    end

    // Strict less-than keeps the lowest index on a tie.
    always_comb begin
        logic [CNT_W-1:0] best_cnt;
        pick     = '0;
        best_cnt = s_q.cnt[0];
        for (int i = 1; i < int'(N_UNITS); i++) begin
            if (s_q.cnt[i] < best_cnt) begin
                best_cnt = s_q.cnt[i];
                pick     = UNIT_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tdr_ret_arbiter.sv
module tdr_ret_arbiter #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned UNIT_W  = 2
) (
    input  logic [N_UNITS-1:0] req,
    output logic [N_UNITS-1:0] grant,
    output logic [UNIT_W-1:0]  grant_idx,
    output logic               any
);
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = 0; i < int'(N_UNITS); i++) begin
            if (req[i] && !any) begin
                grant[i]  = 1'b1;
                grant_idx = UNIT_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdr_reorder_store.sv
module tdr_reorder_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              out_ready,
    output logic [TAG_W-1:0]  tail_tag,
    output logic              full,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [TAG_W-1:0]             head;
        logic [TAG_W-1:0]             tail;
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_state_t;

    store_state_t     s_d, s_q;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             pop;

    assign head_idx  = s_q.head[IDX_W-1:0];
    assign wr_idx    = wr_tag[IDX_W-1:0];
    assign tail_tag  = s_q.tail;
    assign full      = (s_q.tail - s_q.head) == TAG_W'(DEPTH);
    assign out_valid = s_q.vld[head_idx];
    assign out_data  = s_q.mem[head_idx];
    assign pop       = out_valid && out_ready;

    always_comb begin
        s_d = s_q;
        if (alloc)
            s_d.tail = s_q.tail + TAG_W'(1);
        if (wr_en) begin
            s_d.vld[wr_idx] = 1'b1;
            s_d.mem[wr_idx] = wr_data;
        end
        if (pop) begin
            s_d.vld[head_idx] = 1'b0;
            s_d.head          = s_q.head + TAG_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tag_dispatch_reorder.sv
module tag_dispatch_reorder #(
    parameter int unsigned N_UNITS = tdr_pkg::TDR_UNITS_DEF,
    parameter int unsigned DEPTH   = tdr_pkg::TDR_DEPTH_DEF,
    parameter int unsigned DATA_W  = tdr_pkg::TDR_DATA_W_DEF,
    localparam int unsigned TAG_W  = tdr_pkg::tdr_tag_width(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    output logic                      in_ready,
    output logic [N_UNITS-1:0]        disp_valid,
    output logic [N_UNITS*DATA_W-1:0] disp_data,
    output logic [N_UNITS*TAG_W-1:0]  disp_tag,
    input  logic [N_UNITS-1:0]        disp_ready,
    input  logic [N_UNITS-1:0]        res_valid,
    input  logic [N_UNITS*DATA_W-1:0] res_data,
    input  logic [N_UNITS*TAG_W-1:0]  res_tag,
    output logic [N_UNITS-1:0]        res_ready,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    input  logic                      out_ready
);
    localparam int unsigned UNIT_W = tdr_pkg::tdr_index_width(N_UNITS);
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

    logic [UNIT_W-1:0] pick;
    logic [UNIT_W-1:0] grant_idx;
    logic              grant_any;
    logic              full;
    logic [TAG_W-1:0]  tail_tag;
    logic              disp_fire;

    assign in_ready  = !full && disp_ready[pick];
    assign disp_fire = in_valid && in_ready;

    for (genvar g = 0; g < int'(N_UNITS); g++) begin : g_lane
        assign disp_valid[g]                  = in_valid && !full && (pick == UNIT_W'(g));
        assign disp_data[g*DATA_W +: DATA_W]  = in_data;
        assign disp_tag[g*TAG_W +: TAG_W]     = tail_tag;
    end

    tdr_busy_track #(
        .N_UNITS(N_UNITS), .CNT_W(CNT_W), .UNIT_W(UNIT_W)
    ) busy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_fire (disp_fire),
        .disp_unit (pick),
        .ret_fire  (grant_any),
        .ret_unit  (grant_idx),
        .pick      (pick)
    );

    tdr_ret_arbiter #(
        .N_UNITS(N_UNITS), .UNIT_W(UNIT_W)
    ) arb_i (
        .req       (res_valid),
        .grant     (res_ready),
        .grant_idx (grant_idx),
        .any       (grant_any)
    );

    tdr_reorder_store #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (disp_fire),
        .wr_en     (grant_any),
        .wr_tag    (res_tag[grant_idx*TAG_W +: TAG_W]),
        .wr_data   (res_data[grant_idx*DATA_W +: DATA_W]),
        .out_ready (out_ready),
        .tail_tag  (tail_tag),
        .full      (full),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned TAG_W   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic [N_UNITS-1:0]       disp_valid,
    input logic [N_UNITS*TAG_W-1:0] disp_tag,
    input logic [N_UNITS-1:0]       res_valid,
    input logic [N_UNITS-1:0]       res_ready,
    input logic                     out_valid,
    input logic [DATA_W-1:0]        out_data,
    input logic                     out_ready
);
    logic [TAG_W-1:0] seq_q;
    logic [TAG_W-1:0] fired_tag;
    int               occ_q;

    always_comb begin
        fired_tag = '0;
        for (int i = 0; i < int'(N_UNITS); i++)
            if (disp_valid[i]) fired_tag = fired_tag | disp_tag[i*TAG_W +: TAG_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
            occ_q <= 0;
        end else begin
            if (in_valid && in_ready) seq_q <= seq_q + TAG_W'(1);
            occ_q <= occ_q + ((in_valid && in_ready) ? 1 : 0) - ((out_valid && out_ready) ? 1 : 0);
        end
    end

    a_r4_disp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_valid));
    a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_ready));
    a_r6_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ready & ~res_valid) == '0);
    a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == int'(DEPTH)) |-> !in_ready);
    a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= int'(DEPTH));
    a_r2_tag_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (fired_tag == seq_q));
    a_r8_out_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occ_q != 0));
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind tag_dispatch_reorder tdr_checker #(
    .N_UNITS(N_UNITS), .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready)
);

// File: tb/tag_dispatch_reorder_tb_top.sv
module tag_dispatch_reorder_tb_top;
    localparam int NU    = 4;
    localparam int DEPTH = 16;
    localparam int DW    = 16;
    localparam int TW    = 5;
    localparam int WD_LIMIT = 60000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              in_valid;
    logic [DW-1:0]     in_data;
    logic              in_ready;
    logic [NU-1:0]     disp_valid;
    logic [NU*DW-1:0]  disp_data;
    logic [NU*TW-1:0]  disp_tag;
    logic [NU-1:0]     disp_ready;
    logic [NU-1:0]     res_valid;
    logic [NU*DW-1:0]  res_data;
    logic [NU*TW-1:0]  res_tag;
    logic [NU-1:0]     res_ready;
    logic              out_valid;
    logic [DW-1:0]     out_data;
    logic              out_ready;

    tag_dispatch_reorder #(.N_UNITS(NU), .DEPTH(DEPTH), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .disp_valid(disp_valid), .disp_data(disp_data), .disp_tag(disp_tag), .disp_ready(disp_ready),
        .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag), .res_ready(res_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    typedef struct {
        int            seq;
        logic [DW-1:0] data;
        int            due;
    } job_t;

    job_t          uq[NU][$];
    logic [DW-1:0] exp_q[$];
    bit            ret_seen[int];
    int            busy[NU];
    int            lat_base[NU];
    int            lat_span[NU];
    int            p_in, p_out, p_dr;
    int            accepted, delivered, occ, cyc;
    int            checks, failures;
    bit            wd, pend, held;
    logic [DW-1:0] held_val;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        int       esel, gidx;
        bit       exp_rdy, exp_ov, in_fire;
        logic [NU-1:0] exp_grant;
        @(negedge clk);
        cyc++;
        if (cyc > WD_LIMIT && !wd) begin
            wd = 1'b1;
            chk(1'b0, "WATCHDOG", "run did not finish", cyc, WD_LIMIT);
        end
        // drive inputs
        if (!pend) begin
            in_valid = (($urandom % 100) < p_in);
            in_data  = DW'($urandom);
            pend     = in_valid;
        end
        out_ready = (($urandom % 100) < p_out);
        for (int u = 0; u < NU; u++) begin
            disp_ready[u] = (($urandom % 100) < p_dr);
            if (uq[u].size() > 0 && uq[u][0].due <= cyc) begin
                res_valid[u]          = 1'b1;
                res_tag[u*TW +: TW]   = TW'(uq[u][0].seq % (2*DEPTH));
                res_data[u*DW +: DW]  = ~uq[u][0].data;
            end else begin
                res_valid[u]          = 1'b0;
                res_tag[u*TW +: TW]   = '0;
                res_data[u*DW +: DW]  = '0;
            end
        end
        #1;
        // reference expectations
        esel = 0;
        for (int u = 1; u < NU; u++) if (busy[u] < busy[esel]) esel = u;
        exp_rdy = (occ < DEPTH) && disp_ready[esel];
        chk(in_ready == exp_rdy, "R5", "in_ready", in_ready, exp_rdy);
        if (in_valid && occ < DEPTH) begin
            chk(disp_valid == NU'(1 << esel), "R3", "disp_valid unit choice", disp_valid, 1 << esel);
            chk(disp_data[esel*DW +: DW] == in_data, "R4", "disp_data", disp_data[esel*DW +: DW], in_data);
            if (accepted >= 2*DEPTH)
                chk(disp_tag[esel*TW +: TW] == TW'(accepted % (2*DEPTH)), "R10", "wrapped tag",
                    disp_tag[esel*TW +: TW], accepted % (2*DEPTH));
            else
                chk(disp_tag[esel*TW +: TW] == TW'(accepted), "R2", "tag",
                    disp_tag[esel*TW +: TW], accepted);
        end else begin
            chk(disp_valid == '0, "R4", "disp_valid idle", disp_valid, 0);
        end
        exp_grant = '0;
        gidx = -1;
        for (int u = 0; u < NU; u++) if (res_valid[u] && gidx < 0) begin
            exp_grant[u] = 1'b1;
            gidx = u;
        end
        chk(res_ready == exp_grant, "R6", "res_ready", res_ready, exp_grant);
        exp_ov = (occ > 0) && ret_seen.exists(delivered);
        chk(out_valid == exp_ov, "R8", "out_valid", out_valid, exp_ov);
        if (exp_ov) begin
            chk(out_data == exp_q[0], "R7", "out_data order", out_data, exp_q[0]);
            if (held) chk(out_data == held_val, "R9", "held out_data", out_data, held_val);
        end
        // model update for the coming edge
        in_fire = in_valid && exp_rdy;
        if (in_fire) begin
            job_t j;
            j.seq  = accepted;
            j.data = in_data;
            j.due  = cyc + lat_base[esel] + (($urandom % 1000) % (lat_span[esel] + 1));
            uq[esel].push_back(j);
            exp_q.push_back(~in_data);
            busy[esel]++;
            accepted++;
            occ++;
            pend = 1'b0;
        end
        if (gidx >= 0) begin
            ret_seen[uq[gidx][0].seq] = 1'b1;
            void'(uq[gidx].pop_front());
            busy[gidx]--;
        end
        held = exp_ov && !out_ready;
        held_val = out_data;
        if (exp_ov && out_ready) begin
            void'(exp_q.pop_front());
            ret_seen.delete(delivered);
            delivered++;
            occ--;
        end
    endtask

    task automatic set_lat(int u, int b, int s);
        lat_base[u] = b;
        lat_span[u] = s;
    endtask

    initial begin
        checks = 0; failures = 0; cyc = 0; wd = 0; pend = 0; held = 0; held_val = '0;
        accepted = 0; delivered = 0; occ = 0;
        for (int u = 0; u < NU; u++) begin busy[u] = 0; set_lat(u, 1, 2); end
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        disp_ready = '1; res_valid = '0; res_data = '0; res_tag = '0;
        repeat (3) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(res_ready == '0, "R1", "res_ready after reset", res_ready, 0);
        chk(disp_valid == '0, "R1", "disp_valid after reset", disp_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        rst_n = 1'b1;

        // Phase A: unit 0 slow, blocks the head while others complete (R8)
        set_lat(0, 25, 0);
        for (int u = 1; u < NU; u++) set_lat(u, 1, 2);
        p_in = 100; p_out = 100; p_dr = 100;
        while (accepted < 40 && !wd) step();

        // Phase B: randomized latencies and backpressure, many tag wraps (R10)
        for (int u = 0; u < NU; u++) set_lat(u, 1, 14);
        p_in = 70; p_out = 60; p_dr = 80;
        while (accepted < 440 && !wd) step();

        // Phase C: stalled consumer fills the store (R5), then releases
        p_in = 100; p_out = 0; p_dr = 100;
        repeat (80) if (!wd) step();
        chk(occ == DEPTH, "R5", "store filled during stall", occ, DEPTH);
        p_out = 100;
        while (accepted < 520 && !wd) step();

        // Drain
        p_in = 0; p_out = 100;
        while ((occ > 0 || pend) && !wd) begin
            if (pend) p_in = 100; else p_in = 0;
            step();
        end
        repeat (5) if (!wd) step();
        chk(delivered == accepted, "R7", "all items delivered", delivered, accepted);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule